// File: doc/BRIEF.md
# UART register front-end on an APB slave port

This block is the software-facing half of a UART. It sits on an APB slave port and holds a control register, a status register and a receive byte FIFO. Behind it sit two byte streams, each with a valid/ready handshake: a transmit stream toward a serializer and a receive stream from a deserializer. The serial bit framing, baud generation and parity logic live elsewhere. The block drives one interrupt line.

Software writes the data register to send a byte. It reads the data register to take the oldest received byte out of the FIFO. Control bits gate both directions: the receive enable lets incoming bytes into the FIFO, and the transmit enable lets data-register writes out onto the stream. Two separate interrupt enables turn accepted receive bytes and accepted transmit writes into one-clock interrupt pulses. Status bits report:

- whether data is waiting,
- the fill level of the FIFO,
- receive overrun,
- whether a transmit byte is still pending.

Only the low 8 address bits are decoded. The map holds these registers:

| Offset | Register | Behaviour |
|---|---|---|
| 0x00 | data | read pops, write sends |
| 0x03 | data | alias of offset 0x00 |
| 0x04 | status | read-only |
| 0x08 | control | read/write, 32 bits |
| 0x0C | scaler | reads 0, writes ignored |
| 0x10 | FIFO debug | reads 0 |

Top module: `uart_fe_top`

## Requirements
- R1: After reset the control register reads 0x00000000, status reads 0x00000006 (bits 1 and 2 set), irq is 0, tx_valid is 0 and rx_ready is 1.
- R2: The control register at offset 0x08 stores all 32 bits of a write, bit 31 included, and reads them back unchanged.
- R3: The data register answers at offset 0x00 and at offset 0x03. Writes to status (0x04) and scaler (0x0C) change nothing. Reads of scaler, of 0x10 and of any undecoded offset return 0.
- R4: A receive byte is stored only while control bit 0 (receive enable) is 1. While control bit 0 is 0, rx_ready still follows the FIFO (high unless the FIFO is full) and offered bytes are discarded. Every stored byte sets status bit 0 (data ready).
- R5: Reads of the data register return the stored bytes oldest first. Status bit 0 clears when the read takes out the last stored byte. A data read while the FIFO is empty returns 0 and leaves status bit 0 at 0.
- R6: rx_ready is 0 while the FIFO holds DEPTH bytes. Status bit 10 is 1 exactly when the FIFO is full, and status bit 8 is 1 when it holds at least DEPTH/2 bytes.
- R7: A byte offered while the FIFO is full and control bit 0 is 1 is dropped and sets status bit 4 (overrun). Status bit 4 then stays set until reset.
- R8: A data-register write while control bit 1 (transmit enable) is 1 presents pwdata[7:0] on tx_data. tx_valid is held with a stable byte until tx_ready is seen. With control bit 1 at 0 nothing is sent. A write while a byte is still pending replaces that byte.
- R9: Status bits 1 and 2 are 1 when no transmit byte is pending and 0 while one is. Status bit 9 is 1 while a byte is pending.
- R10: irq is high in the cycle after an accepted receive byte when control bit 2 is 1. It is also high in the cycle after an accepted transmit write when control bit 3 is 1. It is low at all other times, which makes each event a single-clock pulse.
- R11: pready is always 1 and pslverr always 0. Register side effects take place only in the access phase (psel and penable both 1). A setup-only cycle pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address; the low 8 bits are decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte is pending |
| tx_ready | input | 1 | Consumer takes the transmit byte |
| rx_data | input | 8 | Receive byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | FIFO has room |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with DEPTH set to 8 instead of 1024. This brings the half and full flags, rx_ready deassertion and the overrun path within a few dozen cycles, while the pointer wrap and the order of bytes across a full FIFO are still exercised. ADDR_W stays at 8, so every decoded offset and one undecoded offset are reachable directly.

// File: rtl/uart_fe_pkg.sv
// Package: register offsets and bit positions of the UART front-end.
// Assumes byte addressing with the low 8 address bits decoded.
package uart_fe_pkg;
    localparam int DEC_W = 8;

    localparam logic [DEC_W-1:0] OFF_DATA   = 8'h00;
    localparam logic [DEC_W-1:0] OFF_DATA_B = 8'h03;
    localparam logic [DEC_W-1:0] OFF_STAT   = 8'h04;
    localparam logic [DEC_W-1:0] OFF_CTRL   = 8'h08;
    localparam logic [DEC_W-1:0] OFF_SCALE  = 8'h0C;
    localparam logic [DEC_W-1:0] OFF_DEBUG  = 8'h10;

    // status bit positions
    localparam int ST_DREADY  = 0;
    localparam int ST_SHIFT_E = 1;
    localparam int ST_TXQ_E   = 2;
    localparam int ST_OVR     = 4;
    localparam int ST_RX_HALF = 8;
    localparam int ST_TX_FULL = 9;
    localparam int ST_RX_FULL = 10;

    // control bit positions
    localparam int CT_RXEN = 0;
    localparam int CT_TXEN = 1;
    localparam int CT_RXIE = 2;
    localparam int CT_TXIE = 3;
endpackage

// File: rtl/uart_fe_rxfifo.sv
// Receive byte FIFO with an asynchronous head read.
// Assumes DEPTH is a power of two. A pop while empty is ignored.
module uart_fe_rxfifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; the array itself carries no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/uart_fe_txhold.sv
// One-byte transmit holding stage toward the serializer stream.
// A new load replaces any byte still pending.
module uart_fe_txhold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] data
);
    // Hold the byte until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= din;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_fe_irq.sv
// Interrupt pulse generator: one registered clock of irq per enabled event.
// Simultaneous events give a single pulse.
module uart_fe_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_evt,
    input  logic tx_evt,
    input  logic rx_ie,
    input  logic tx_ie,
    output logic irq
);
    // Register the enabled events into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (rx_evt && rx_ie) || (tx_evt && tx_ie);
    end
endmodule

// File: rtl/uart_fe_top.sv
// UART register front-end: APB decode, control and status registers,
// receive FIFO, transmit holding stage and interrupt pulses.
// Assumes ADDR_W >= 8. Transfers finish in one access cycle.
module uart_fe_top
    import uart_fe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 1024
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic [DEC_W-1:0] off;
    logic             access;
    logic             is_data;
    logic             wr_data_fire;
    logic             rd_data_fire;
    logic             tx_load;
    logic             rx_push;
    logic [31:0]      ctrl;
    logic [31:0]      status;
    logic             data_ready;
    logic             ovr;
    logic [7:0]       fifo_head;
    logic [CW-1:0]    rx_count;
    logic             rx_full;
    logic             rx_empty;

    assign pready       = 1'b1;
    assign pslverr      = 1'b0;
    assign off          = paddr[DEC_W-1:0];
    assign access       = psel && penable;
    assign is_data      = (off == OFF_DATA) || (off == OFF_DATA_B);
    assign wr_data_fire = access && pwrite && is_data;
    assign rd_data_fire = access && !pwrite && is_data;
    assign tx_load      = wr_data_fire && ctrl[CT_TXEN];
    assign rx_ready     = !rx_full;
    assign rx_push      = rx_valid && rx_ready && ctrl[CT_RXEN];

    uart_fe_rxfifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk   (pclk),
        .rst_n (presetn),
        .push  (rx_push),
        .din   (rx_data),
        .pop   (rd_data_fire),
        .dout  (fifo_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    uart_fe_txhold #(.W(8)) u_tx (
        .clk   (pclk),
        .rst_n (presetn),
        .load  (tx_load),
        .din   (pwdata[7:0]),
        .ready (tx_ready),
        .valid (tx_valid),
        .data  (tx_data)
    );

    uart_fe_irq u_irq (
        .clk    (pclk),
        .rst_n  (presetn),
        .rx_evt (rx_push),
        .tx_evt (tx_load),
        .rx_ie  (ctrl[CT_RXIE]),
        .tx_ie  (ctrl[CT_TXIE]),
        .irq    (irq)
    );

    // Control register: full-width store on an access-phase write.
    always_ff @(posedge pclk) begin
        if (!presetn)                              ctrl <= '0;
        else if (access && pwrite && off == OFF_CTRL) ctrl <= pwdata;
    end

    // Data-ready flag: set by a stored byte, cleared when the FIFO drains.
    always_ff @(posedge pclk) begin
        if (!presetn)
            data_ready <= 1'b0;
        else if (rx_push)
            data_ready <= 1'b1;
        else if (rd_data_fire && (rx_empty || rx_count == CW'(1)))
            data_ready <= 1'b0;
    end

    // Sticky overrun flag: a byte offered while full and enabled.
    always_ff @(posedge pclk) begin
        if (!presetn)                                 ovr <= 1'b0;
        else if (rx_valid && rx_full && ctrl[CT_RXEN]) ovr <= 1'b1;
    end

    // Status word assembly.
    always_comb begin
        status             = '0;
        status[ST_DREADY]  = data_ready;
        status[ST_SHIFT_E] = !tx_valid;
        status[ST_TXQ_E]   = !tx_valid;
        status[ST_OVR]     = ovr;
        status[ST_RX_HALF] = (rx_count >= CW'(DEPTH/2));
        status[ST_TX_FULL] = tx_valid;
        status[ST_RX_FULL] = rx_full;
    end

    // Read data multiplexer; undecoded offsets read as zero.
    always_comb begin
        prdata = '0;
        if (is_data)              prdata = rx_empty ? 32'h0 : {24'h0, fifo_head};
        else if (off == OFF_STAT) prdata = status;
        else if (off == OFF_CTRL) prdata = ctrl;
    end
endmodule

// File: rtl/uart_fe_chk.sv
// Checker for uart_fe_top, bound to every instance of it.
// Observes ports plus control, FIFO occupancy and flag state.
module uart_fe_chk #(
    parameter int DEPTH = 1024,
    parameter int CW    = $clog2(DEPTH+1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          psel,
    input logic          penable,
    input logic          pwrite,
    input logic [7:0]    off,
    input logic          pready,
    input logic          pslverr,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          irq,
    input logic [31:0]   ctrl,
    input logic [CW-1:0] count,
    input logic          data_ready,
    input logic          ovr
);
    logic data_wr;
    logic rx_cause;
    logic tx_cause;

    assign data_wr  = psel && penable && pwrite && (off == 8'h00 || off == 8'h03);
    assign rx_cause = rx_valid && rx_ready && ctrl[0] && ctrl[2];
    assign tx_cause = data_wr && ctrl[1] && ctrl[3];

    p_apb_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);
    p_no_pop_outside_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable) |=> count >= $past(count));
    p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !rx_ready);
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr);
    p_dready_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready == (count != '0));
    p_store_sets_dready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && ctrl[0]) |=> data_ready);
    p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !data_wr) |=> (tx_valid && $stable(tx_data)));
    p_irq_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(rx_cause || tx_cause));
    p_cause_gives_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cause || tx_cause) |=> irq);
endmodule

bind uart_fe_top uart_fe_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH+1))) u_chk (
    .clk        (pclk),
    .rst_n      (presetn),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .off        (paddr[7:0]),
    .pready     (pready),
    .pslverr    (pslverr),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .irq        (irq),
    .ctrl       (ctrl),
    .count      (rx_count),
    .data_ready (data_ready),
    .ovr        (ovr)
);

// File: tb/sim_uart_fe_top.sv
// Scoreboard bench: tasks drive APB and receive traffic and queue expected
// bytes; a monitor checks each transmit handshake against the queue.
module sim_uart_fe_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        irq;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];
    logic [31:0] rd;
    logic [31:0] ctrl_shadow = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fe_top #(.ADDR_W(8), .DEPTH(DEPTH)) u0 (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1 r = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic set_ctrl(input logic [31:0] v);
        logic [31:0] r;
        apb(1'b1, 8'h08, v, r);
        ctrl_shadow = v;
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        if (ctrl_shadow[0] && rx_q.size() < DEPTH) rx_q.push_back(b);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rx_read(input logic [7:0] a, input string tag);
        logic [31:0] r;
        logic [7:0]  e;
        e = (rx_q.size() != 0) ? rx_q.pop_front() : 8'h00;
        apb(1'b0, a, 32'h0, r);
        chk(tag, r, {24'h0, e});
    endtask

    task automatic tx_write(input logic [7:0] a, input logic [31:0] d, input bit replace);
        logic [31:0] r;
        if (ctrl_shadow[1]) begin
            if (replace && tx_q.size() != 0) void'(tx_q.pop_back());
            tx_q.push_back(d[7:0]);
        end
        apb(1'b1, a, d, r);
    endtask

    // Transmit monitor: each handshake must match the oldest expected byte (R8).
    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (tx_q.size() == 0) chk("R8 unexpected tx byte", {24'h0, tx_data}, 32'hFFFF_FFFF);
            else                  chk("R8 tx byte", {24'h0, tx_data}, {24'h0, tx_q.pop_front()});
        end
    end

    // APB response must be ready with no error at all times (R11).
    always @(negedge clk) begin
        if (rst_n && (pready !== 1'b1 || pslverr !== 1'b0))
            chk("R11 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        chk("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
        apb(1'b0, 8'h04, 0, rd); chk("R1 status", rd, 32'h6);
        apb(1'b0, 8'h08, 0, rd); chk("R1 control", rd, 32'h0);

        // R2 full-width control
        set_ctrl(32'h8000_1230);
        apb(1'b0, 8'h08, 0, rd); chk("R2 control readback", rd, 32'h8000_1230);
        set_ctrl(32'h0);

        // R4 receive disabled: byte discarded, rx_ready high
        chk("R4 rx_ready while disabled", {31'h0, rx_ready}, 32'h1);
        rx_send(8'h55);
        apb(1'b0, 8'h04, 0, rd); chk("R4 no data ready when disabled", rd, 32'h6);
        rx_read(8'h00, "R4 discarded byte reads 0");

        // R4/R5 enabled: order, alias, data-ready clear, empty read
        set_ctrl(32'h1);
        rx_send(8'hA1); chk("R10 no irq without enable", {31'h0, irq}, 32'h0);
        rx_send(8'hB2); rx_send(8'hC3);
        apb(1'b0, 8'h04, 0, rd); chk("R4 data ready set", rd & 32'h1, 32'h1);
        rx_read(8'h00, "R5 first byte");
        rx_read(8'h03, "R3 alias read");
        apb(1'b0, 8'h04, 0, rd); chk("R5 data ready before last", rd & 32'h1, 32'h1);
        rx_read(8'h00, "R5 last byte");
        apb(1'b0, 8'h04, 0, rd); chk("R5 data ready clears", rd & 32'h1, 32'h0);
        rx_read(8'h00, "R5 empty read");
        apb(1'b0, 8'h04, 0, rd); chk("R5 data ready stays clear", rd & 32'h1, 32'h0);

        // R10 receive interrupt pulse
        set_ctrl(32'h5);
        rx_send(8'h3C);
        chk("R10 rx irq high", {31'h0, irq}, 32'h1);
        @(negedge clk);
        chk("R10 rx irq one cycle", {31'h0, irq}, 32'h0);
        rx_read(8'h00, "R10 drain byte");

        // R6/R7 fill, full, overrun, wrap order
        set_ctrl(32'h1);
        for (int i = 0; i < DEPTH; i++) begin
            rx_send(8'h10 + 8'(i));
            if (i == DEPTH/2 - 2) begin
                apb(1'b0, 8'h04, 0, rd); chk("R6 half clear below half", rd & 32'h100, 32'h0);
            end
            if (i == DEPTH/2 - 1) begin
                apb(1'b0, 8'h04, 0, rd); chk("R6 half set", rd & 32'h100, 32'h100);
            end
        end
        chk("R6 rx_ready low when full", {31'h0, rx_ready}, 32'h0);
        apb(1'b0, 8'h04, 0, rd); chk("R6 full flag", rd & 32'h410, 32'h400);
        rx_send(8'hEE);
        apb(1'b0, 8'h04, 0, rd); chk("R7 overrun set", rd & 32'h10, 32'h10);
        // R11 setup-only cycle must not pop
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 8'h00;
        @(negedge clk); psel = 1'b0;
        chk("R11 setup-only keeps full", {31'h0, rx_ready}, 32'h0);
        for (int i = 0; i < DEPTH; i++) rx_read(8'h00, "R6 byte order through full FIFO");
        chk("R6 rx_ready back", {31'h0, rx_ready}, 32'h1);
        apb(1'b0, 8'h04, 0, rd); chk("R7 overrun sticky", rd, 32'h16 & 32'h16 ^ 32'h0 ? 32'h16 : 32'h16);
        // refill past wrap to check ordering again
        rx_send(8'h77); rx_send(8'h88);
        rx_read(8'h00, "R5 after wrap 1"); rx_read(8'h03, "R5 after wrap 2");

        // R3 ignored writes and zero reads
        apb(1'b1, 8'h04, 32'hFFFF_FFFF, rd);
        apb(1'b0, 8'h04, 0, rd); chk("R3 status write ignored", rd, 32'h16);
        apb(1'b1, 8'h0C, 32'h1234, rd);
        apb(1'b0, 8'h0C, 0, rd); chk("R3 scaler reads 0", rd, 32'h0);
        apb(1'b0, 8'h10, 0, rd); chk("R3 debug reads 0", rd, 32'h0);
        apb(1'b0, 8'h24, 0, rd); chk("R3 undecoded reads 0", rd, 32'h0);
        apb(1'b0, 8'h08, 0, rd); chk("R3 control intact", rd, 32'h1);

        // R8/R10 transmit with interrupt
        set_ctrl(32'hA);
        tx_write(8'h00, 32'h0000_01A5, 0);
        chk("R10 tx irq high", {31'h0, irq}, 32'h1);
        @(negedge clk);
        chk("R10 tx irq one cycle", {31'h0, irq}, 32'h0);
        tx_write(8'h03, 32'h0000_005A, 0);
        repeat (2) @(negedge clk);

        // R8 transmit disabled
        set_ctrl(32'h8);
        tx_write(8'h00, 32'h66, 0);
        chk("R8 no tx when disabled", {31'h0, tx_valid}, 32'h0);
        chk("R10 no irq when tx disabled", {31'h0, irq}, 32'h0);

        // R8/R9 backpressure and replacement
        set_ctrl(32'h2);
        tx_ready = 1'b0;
        tx_write(8'h00, 32'h11, 0);
        chk("R8 tx_valid held", {31'h0, tx_valid}, 32'h1);
        chk("R8 tx_data", {24'h0, tx_data}, 32'h11);
        apb(1'b0, 8'h04, 0, rd); chk("R9 pending status", rd & 32'h206, 32'h200);
        tx_write(8'h00, 32'h22, 1);
        chk("R8 replaced byte", {24'h0, tx_data}, 32'h22);
        tx_ready = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 tx_valid drops", {31'h0, tx_valid}, 32'h0);
        apb(1'b0, 8'h04, 0, rd); chk("R9 idle status", rd & 32'h206, 32'h6);
        chk("R8 all tx bytes seen", tx_q.size(), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule